// File: doc/BRIEF.md
# Parallel NRZI Decoder and Bit Destuffer

This block takes 16-bit words of NRZI-coded line samples and returns clean 16-bit data words. Each word is qualified by `in_valid`. The core clock runs at three times the word rate, so every accepted word is processed in a fixed three-cycle slot.

Within that slot the word is first NRZI-decoded, least significant bit first. Stuffed bits are then found and deleted. The surviving bits are packed without gaps on top of any bits left over from earlier words. As soon as sixteen decoded bits are held, they leave on `out_word` with a one-cycle `out_strobe`. The positions of up to two deleted bits in the latest input word are reported alongside.

The controller has four states:
- `ST_INIT` is entered on reset and always moves on to `ST_WAIT` after one cycle.
- `ST_WAIT` idles until `in_valid` is high. It then captures `in_word` and moves to `ST_DECODE`.
- `ST_DECODE` registers the decoded bits and always moves to `ST_UNSTUFF`.
- `ST_UNSTUFF` removes stuffed bits, packs the rest, updates the outputs, and always returns to `ST_WAIT`.

Top module: `word_destuffer`

## Requirements
- R1: A word is captured only when `in_valid` is high while the controller is in `ST_WAIT`. `in_valid` and `in_word` have no effect during `ST_INIT`, `ST_DECODE` and `ST_UNSTUFF`.
- R2: A word captured at clock edge k updates the outputs at edge k+2. `out_strobe` is low after edge k+1. The next word can be captured at edge k+3.
- R3: Bit i of `in_word` is decoded to 1 when its level equals the previous level, and to 0 when the level toggles. For bit 0 the previous level is bit 15 of the previously captured word, or 1 after reset.
- R4: A decoded bit that directly follows six consecutive decoded 1s is deleted, whatever its value. The run count carries across words. It is cleared by a decoded 0 and by a deleted bit.
- R5: Kept bits are packed without gaps in arrival order. Earlier bits go to lower bit positions of `out_word`, and leftover bits from earlier words come first.
- R6: When at least 16 bits are held after a word, the oldest 16 appear on `out_word` and `out_strobe` is high for exactly one cycle. The remaining bits are kept. Otherwise `out_strobe` stays low and `out_word` keeps its previous value.
- R7: `del_pos_a`/`del_vld_a` give the bit index (0..15) of the lowest deleted bit in the latest word, and `del_pos_b`/`del_vld_b` give the second. A valid flag is low when fewer bits were deleted. These outputs are held until the next word's update.
- R8: A synchronous reset sets `out_strobe`, `out_word`, both valid flags and both positions to 0. It also empties the bit store, clears the run count and sets the previous line level to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, three times the word rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_word` |
| in_word | input | 16 | NRZI line levels, bit 0 earliest |
| out_strobe | output | 1 | One-cycle pulse marking a new `out_word` |
| out_word | output | 16 | Cleaned decoded data, bit 0 earliest |
| del_pos_a | output | 5 | Index of the first deleted bit of the latest word |
| del_vld_a | output | 1 | `del_pos_a` is meaningful |
| del_pos_b | output | 5 | Index of the second deleted bit of the latest word |
| del_vld_b | output | 1 | `del_pos_b` is meaningful |

## Verification
The hardest case to reach from the ports is a word whose first bit is deleted because the six 1s came from the previous word. The same word then carries two more deletions, so three bits vanish at once. Since the line levels depend on the whole history, the bench builds stimulus from the decoded pattern it wants. It NRZI-encodes that pattern against the line level left by the previous word, and in this way steers the run count across word boundaries on purpose.

// File: rtl/nd_pkg.sv
package nd_pkg;
    typedef enum logic [1:0] {
        ST_INIT,
        ST_WAIT,
        ST_DECODE,
        ST_UNSTUFF
    } nd_state_e;
endpackage

// File: rtl/nd_nrzi_dec.sv
module nd_nrzi_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] line,
    input  logic         hist,
    output logic [W-1:0] bits,
    output logic         last_level
);
    // a 1 means no transition relative to the preceding level
    assign bits[0] = ~(line[0] ^ hist);
    for (genvar g = 1; g < W; g++) begin : g_bit
        assign bits[g] = ~(line[g] ^ line[g-1]);
    end
    assign last_level = line[W-1];
endmodule

// File: rtl/nd_unstuff.sv
module nd_unstuff #(
    parameter int W     = 16,
    parameter int RUN   = 6,
    parameter int POS_W = 5,
    parameter int CNT_W = 3
) (
    input  logic [W-1:0]     bits,
    input  logic [CNT_W-1:0] run_in,
    output logic [W-1:0]     packed_bits,
    output logic [POS_W-1:0] kept_cnt,
    output logic [CNT_W-1:0] run_out,
    output logic [POS_W-1:0] pos0,
    output logic             vld0,
    output logic [POS_W-1:0] pos1,
    output logic             vld1
);
    localparam int IDX_W = $clog2(W);

    always_comb begin
        logic [CNT_W-1:0] run;
        logic [POS_W-1:0] n;
        run         = run_in;
        n           = '0;
        packed_bits = '0;
        pos0        = '0;
        pos1        = '0;
        vld0        = 1'b0;
        vld1        = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (run == CNT_W'(RUN)) begin
                // drop this bit, remember where it sat
                run = '0;
                if (!vld0) begin
                    vld0 = 1'b1;
                    pos0 = POS_W'(i);
                end else if (!vld1) begin
                    vld1 = 1'b1;
                    pos1 = POS_W'(i);
                end
            end else begin
                packed_bits[n[IDX_W-1:0]] = bits[i];
                n   = n + 1'b1;
                run = bits[i] ? run + 1'b1 : '0;
            end
        end
        kept_cnt = n;
        run_out  = run;
    end
endmodule

// File: rtl/nd_packer.sv
module nd_packer #(
    parameter int W      = 16,
    parameter int BUF_W  = 31,
    parameter int FILL_W = 5,
    parameter int POS_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     din,
    input  logic [POS_W-1:0] din_cnt,
    output logic [W-1:0]     out_word,
    output logic             out_strobe
);
    logic [BUF_W-1:0]  buf_q;
    logic [FILL_W-1:0] fill_q;
    logic [2*W-1:0]    merged;
    logic [FILL_W:0]   total;

    always_comb begin
        merged = {{(2*W-BUF_W){1'b0}}, buf_q} | ({{W{1'b0}}, din} << fill_q);
        total  = {1'b0, fill_q} + (FILL_W+1)'(din_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q      <= '0;
            fill_q     <= '0;
            out_word   <= '0;
            out_strobe <= 1'b0;
        end else begin
            out_strobe <= 1'b0;
            if (load) begin
                if (total >= (FILL_W+1)'(W)) begin
                    out_word   <= merged[W-1:0];
                    out_strobe <= 1'b1;
                    buf_q      <= BUF_W'(merged >> W);
                    fill_q     <= FILL_W'(total - (FILL_W+1)'(W));
                end else begin
                    buf_q  <= merged[BUF_W-1:0];
                    fill_q <= total[FILL_W-1:0];
                end
            end
        end
    end

    AST_FILL_BELOW_WORD: assert property (@(posedge clk) disable iff (rst)
        fill_q < FILL_W'(W)); // R6
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_strobe |=> !out_strobe); // R6
endmodule

// File: rtl/word_destuffer.sv
module word_destuffer #(
    parameter int WORD_W  = 16,
    parameter int RUN_LEN = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_word,
    output logic                        out_strobe,
    output logic [WORD_W-1:0]           out_word,
    output logic [$clog2(WORD_W):0]     del_pos_a,
    output logic                        del_vld_a,
    output logic [$clog2(WORD_W):0]     del_pos_b,
    output logic                        del_vld_b
);
    import nd_pkg::*;

    localparam int POS_W  = $clog2(WORD_W) + 1;
    localparam int CNT_W  = $clog2(RUN_LEN + 1);
    localparam int BUF_W  = 2 * WORD_W - 1;
    localparam int FILL_W = $clog2(BUF_W + 1);

    nd_state_e state_q, state_d;

    logic [WORD_W-1:0] line_q, dec_q, dec_w, packed_w;
    logic              hist_q, last_w;
    logic [CNT_W-1:0]  run_q, run_w;
    logic [POS_W-1:0]  kept_w, pos0_w, pos1_w;
    logic              vld0_w, vld1_w;

    nd_nrzi_dec #(.W(WORD_W)) u_dec (
        .line(line_q), .hist(hist_q), .bits(dec_w), .last_level(last_w)
    );

    nd_unstuff #(.W(WORD_W), .RUN(RUN_LEN), .POS_W(POS_W), .CNT_W(CNT_W)) u_unstuff (
        .bits(dec_q), .run_in(run_q), .packed_bits(packed_w), .kept_cnt(kept_w),
        .run_out(run_w), .pos0(pos0_w), .vld0(vld0_w), .pos1(pos1_w), .vld1(vld1_w)
    );

    nd_packer #(.W(WORD_W), .BUF_W(BUF_W), .FILL_W(FILL_W), .POS_W(POS_W)) u_pack (
        .clk(clk), .rst(rst), .load(state_q == ST_UNSTUFF), .din(packed_w),
        .din_cnt(kept_w), .out_word(out_word), .out_strobe(out_strobe)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_INIT;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:    state_d = ST_WAIT;
            ST_WAIT:    if (in_valid) state_d = ST_DECODE;
            ST_DECODE:  state_d = ST_UNSTUFF;
            ST_UNSTUFF: state_d = ST_WAIT;
        endcase
    end

    // per-state datapath and reported positions
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            hist_q    <= 1'b1;
            dec_q     <= '0;
            run_q     <= '0;
            del_pos_a <= '0;
            del_pos_b <= '0;
            del_vld_a <= 1'b0;
            del_vld_b <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT: if (in_valid) line_q <= in_word;
                ST_DECODE: begin
                    dec_q  <= dec_w;
                    hist_q <= last_w;
                end
                ST_UNSTUFF: begin
                    run_q     <= run_w;
                    del_pos_a <= pos0_w;
                    del_vld_a <= vld0_w;
                    del_pos_b <= pos1_w;
                    del_vld_b <= vld1_w;
                end
                default: ;
            endcase
        end
    end

    AST_DECODE_THEN_UNSTUFF: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DECODE |=> state_q == ST_UNSTUFF); // R2
    AST_UNSTUFF_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_UNSTUFF |=> state_q == ST_WAIT); // R2
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run_q <= CNT_W'(RUN_LEN)); // R4
    AST_POS_ORDER: assert property (@(posedge clk) disable iff (rst)
        del_vld_b |-> (del_vld_a && del_pos_b > del_pos_a)); // R7
    AST_POS_HELD: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_UNSTUFF |=> ($stable(del_pos_a) && $stable(del_vld_a)
                                   && $stable(del_pos_b) && $stable(del_vld_b))); // R7
    AST_CAPTURE_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_WAIT |=> state_q != ST_DECODE); // R1
endmodule

// File: tb/tb_word_destuffer.sv
`timescale 1ns/1ps
module tb_word_destuffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_strobe, del_vld_a, del_vld_b;
    logic [15:0] out_word;
    logic [4:0]  del_pos_a, del_pos_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    word_destuffer dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_strobe(out_strobe), .out_word(out_word),
        .del_pos_a(del_pos_a), .del_vld_a(del_vld_a),
        .del_pos_b(del_pos_b), .del_vld_b(del_vld_b)
    );

    // line words walked in a loop; expectations come from the serial model
    localparam logic [15:0] VEC [12] = '{
        16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5, 16'hFFC0, 16'h003F,
        16'hF0F0, 16'h7FFE, 16'h8001, 16'hCCCC, 16'hFFFF, 16'h5555
    };

    // serial reference model state
    logic        m_prev, m_strobe, m_pav, m_pbv;
    int          m_run, m_fill;
    logic [63:0] m_buf;
    logic [15:0] m_out;
    logic [4:0]  m_pa, m_pb;

    task automatic model_reset();
        m_prev = 1'b1; m_run = 0; m_fill = 0; m_buf = '0; m_out = '0;
        m_strobe = 1'b0; m_pav = 1'b0; m_pbv = 1'b0; m_pa = '0; m_pb = '0;
    endtask

    task automatic model_word(input logic [15:0] line);
        m_pav = 1'b0; m_pbv = 1'b0; m_pa = '0; m_pb = '0; m_strobe = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic d;
            d = (line[i] == m_prev);
            m_prev = line[i];
            if (m_run == 6) begin
                m_run = 0;
                if (!m_pav) begin m_pav = 1'b1; m_pa = 5'(i); end
                else if (!m_pbv) begin m_pbv = 1'b1; m_pb = 5'(i); end
            end else begin
                m_buf[m_fill] = d;
                m_fill++;
                m_run = d ? m_run + 1 : 0;
            end
        end
        if (m_fill >= 16) begin
            m_out = m_buf[15:0];
            m_strobe = 1'b1;
            m_buf = m_buf >> 16;
            m_fill -= 16;
        end
    endtask

    // NRZI-encode a wanted decoded pattern against the current line level
    function automatic logic [15:0] enc(input logic [15:0] dec);
        logic lvl;
        logic [15:0] r;
        lvl = m_prev;
        for (int i = 0; i < 16; i++) begin
            lvl  = dec[i] ? lvl : ~lvl;
            r[i] = lvl;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] line, input bit noisy);
        model_word(line);
        in_valid = 1'b1; in_word = line;
        @(negedge clk);
        in_valid = noisy; in_word = ~line;
        @(negedge clk);
        check("R2 no early strobe", out_strobe, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 strobe", out_strobe, m_strobe);
        check("R5 out_word", out_word, m_out);
        check("R7 vld_a", del_vld_a, m_pav);
        check("R7 vld_b", del_vld_b, m_pbv);
        if (m_pav) check("R4 pos_a", del_pos_a, m_pa);
        if (m_pbv) check("R4 pos_b", del_pos_b, m_pb);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R8 strobe", out_strobe, 1'b0);
        check("R8 word", out_word, 16'h0);
        check("R8 valids", {del_vld_a, del_vld_b}, 2'b00);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] hold_a;
        do_reset();

        // hand-worked cases from reset
        send(16'hAAAA, 1'b0);
        check("R3 all toggles decode to 0", {out_strobe, out_word}, {1'b1, 16'h0000});
        send(enc(16'h003F), 1'b0);
        check("R4 stuffed at 6", {del_vld_a, del_pos_a, out_strobe}, {1'b1, 5'd6, 1'b0});
        send(enc(16'h0001), 1'b0);
        check("R5 packing across words", out_word, 16'h803F);

        // run carried across a word boundary
        send(enc(16'hF000), 1'b0);
        send(enc(16'h0003), 1'b0);
        check("R4 carried run", {del_vld_a, del_pos_a}, {1'b1, 5'd2});

        // two deletions in one word
        send(enc(16'h1FBF), 1'b0);
        check("R7 two deletions", {del_pos_a, del_pos_b}, {5'd6, 5'd13});

        // three deletions, the first from a carried run
        send(enc(16'hFC00), 1'b0);
        send(enc(16'h3F7E), 1'b0);
        check("R7 first two of three", {del_vld_a, del_pos_a, del_vld_b, del_pos_b},
              {1'b1, 5'd0, 1'b1, 5'd7});

        // idle: nothing moves, positions held
        hold_a = del_pos_a;
        repeat (5) begin
            @(negedge clk);
            check("R1 idle no strobe", out_strobe, 1'b0);
        end
        check("R7 held while idle", del_pos_a, hold_a);

        // table walk, every third word with noise on the enable while busy
        for (int k = 0; k < 12; k++) send(VEC[k], (k % 3) == 1);
        send(enc(16'h0000), 1'b1);
        send(enc(16'h0000), 1'b0);

        // reset mid-stream restores level 1 and empties the store
        do_reset();
        send(16'hAAAA, 1'b0);
        check("R8 state cleared", {out_strobe, out_word, del_vld_a}, {1'b1, 16'h0000, 1'b0});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule